// File: doc/BRIEF.md
# Block-Space Eviction Sequencer with Recency Ordering

This block holds a small number of cache slots, each covering one whole flash block of 64 pages. A slot records which block it stands for and a bitmap of the pages it holds valid. A page-space selector loads slots with groups of pages, or exchanges a slot's contents for a new group without touching flash. Reads and writes probe the slots through a lookup port, and every hit makes the slot the most recently used.

When the selector asks for room, the sequencer evicts the least recently used slot. It first fetches from flash only those pages that the slot lacks but that flash still holds as live; this merge happens late, at eviction time. It then erases the flash block once and writes all 64 pages back in ascending order. Each flash command waits for its own done pulse. When the last write completes, the slot is reported free so that the waiting page group can be loaded into it.

Top module: `bsc_block_space`

## Requirements
- R1: After reset every slot is empty, `free_valid` is 1 with `free_slot` 0, `busy` and `fc_valid` are 0, and `lru_slot` is the highest-numbered slot.
- R2: `lk_hit` is 1 exactly when a loaded slot holds block `lk_block` with bit `lk_page` of its page bitmap set, and `lk_slot` then names that slot.
- R3: A load, an exchange or a lookup hit makes the addressed slot the most recent; `lru_slot` always names the least recent slot and `lru_block` gives its block.
- R4: `flush_req` is accepted only when the block is idle and every slot is loaded. An accepted request makes `busy` 1 on the next cycle and evicts the slot that `lru_slot` named. Otherwise the request is ignored.
- R5: Merge reads (`fc_op` = 1) are issued first, in ascending page order, for exactly those pages whose bit is 0 in the slot bitmap and 1 in `flash_live`. `flash_live` is sampled in the cycle of acceptance.
- R6: After the merge reads, exactly one erase (`fc_op` = 3, `fc_page` 0) of the slot's block is issued.
- R7: After the erase, 64 writes (`fc_op` = 2) are issued with `fc_page` running 0 to 63, all to the evicted block's address on `fc_block`.
- R8: When the evicted slot has all 64 bitmap bits set, no read is issued and the first command is the erase.
- R9: Only one command is outstanding at a time. While `fc_valid` is 1 and `fc_done` is 0, op, page and block stay unchanged. The next command appears in the cycle after the done pulse.
- R10: In the cycle after the done pulse of the last write, `busy` is 0, the slot is empty and reported by `free_valid`/`free_slot`, and lookups of its block miss.
- R11: An exchange (`swap_en`) on a loaded slot pulses `hand_valid` one cycle later, with the slot's previous block and bitmap on `hand_block`/`hand_mask`. The slot takes `cmd_block`/`cmd_mask`, and no flash command is issued.
- R12: Load, exchange and flush commands are ignored while `busy` is 1. A load aimed at a loaded slot is ignored, and so is an exchange aimed at an empty slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | 1 | Load an empty slot with a page group |
| swap_en | input | 1 | Exchange a loaded slot's contents for a page group |
| cmd_slot | input | 1 | Slot addressed by load or exchange |
| cmd_block | input | 16 | Block address of the incoming group |
| cmd_mask | input | 64 | Page bitmap of the incoming group |
| hand_valid | output | 1 | Pulse: previous contents handed back |
| hand_block | output | 16 | Block handed back |
| hand_mask | output | 64 | Bitmap handed back |
| lk_en | input | 1 | Lookup strobe |
| lk_block | input | 16 | Lookup block address |
| lk_page | input | 6 | Lookup page index |
| lk_hit | output | 1 | Lookup hit |
| lk_slot | output | 1 | Slot that hit |
| lru_slot | output | 1 | Least recently used slot |
| lru_block | output | 16 | Block held by that slot |
| flush_req | input | 1 | Request eviction of the least recent slot |
| flash_live | input | 64 | Pages of the evicted block still live in flash |
| fc_valid | output | 1 | Flash command valid |
| fc_op | output | 2 | 1 read, 2 write, 3 erase |
| fc_block | output | 16 | Flash block address |
| fc_page | output | 6 | Flash page index |
| fc_done | input | 1 | Completion pulse for the current command |
| busy | output | 1 | Eviction in progress |
| free_valid | output | 1 | An empty slot exists and the block is idle |
| free_slot | output | 1 | Lowest empty slot |

## Verification
The assertions take for granted that no block address is loaded into two slots at once, that `fc_done` is raised only while `fc_valid` is 1, and that load or exchange never shares a cycle with `flush_req`. The stimulus keeps to this by giving each page group a distinct block number. It pulses done once per observed command with a varying delay, and it issues the selector commands one at a time, each in its own cycle.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic [1:0] {
    FOP_NONE  = 2'd0,
    FOP_READ  = 2'd1,
    FOP_WRITE = 2'd2,
    FOP_ERASE = 2'd3
  } fop_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_READ,
    SQ_ERASE,
    SQ_WRITE
  } seq_st_e;
endpackage

// File: rtl/bsc_lru.sv
module bsc_lru #(
  parameter int NUM_SLOTS = 2,
  parameter int SW        = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [SW-1:0] touch_slot,
  output logic [SW-1:0] lru_slot
);
  // Each slot carries an age rank; 0 is most recent, NUM_SLOTS-1 is least.
  logic [SW-1:0]        age_q [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] oldest_hot;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_age
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        age_q[i] <= SW'(i);
      end else if (touch_en) begin
        if (touch_slot == SW'(i))
          age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_slot])
          age_q[i] <= age_q[i] + 1'b1;
      end
    end
    assign oldest_hot[i] = (age_q[i] == SW'(NUM_SLOTS - 1));
  end

  always_comb begin
    lru_slot = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (oldest_hot[i]) lru_slot = SW'(i);
  end

  // R3: ranks remain a permutation, so exactly one slot is oldest
  p_one_oldest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_hot) == 1);
  // R3: a touched slot is never the least recent afterwards
  p_touch_mru_r3: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (lru_slot != $past(touch_slot)));
endmodule

// File: rtl/bsc_slot_store.sv
module bsc_slot_store #(
  parameter int NUM_SLOTS = 2,
  parameter int PAGES     = 64,
  parameter int BLK_W     = 16,
  parameter int SW        = 1,
  parameter int PGW       = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             ld_en,
  input  logic [SW-1:0]                    ld_slot,
  input  logic [BLK_W-1:0]                 ld_block,
  input  logic [PAGES-1:0]                 ld_mask,
  input  logic                             clr_en,
  input  logic [SW-1:0]                    clr_slot,
  input  logic [BLK_W-1:0]                 lk_block,
  input  logic [PGW-1:0]                   lk_page,
  output logic                             lk_hit,
  output logic [SW-1:0]                    lk_slot,
  output logic [NUM_SLOTS-1:0]             vld,
  output logic [NUM_SLOTS-1:0][BLK_W-1:0]  blk,
  output logic [NUM_SLOTS-1:0][PAGES-1:0]  msk
);
  logic [NUM_SLOTS-1:0] hit_vec;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[i] <= 1'b0;
        blk[i] <= '0;
        msk[i] <= '0;
      end else if (ld_en && ld_slot == SW'(i)) begin
        vld[i] <= 1'b1;
        blk[i] <= ld_block;
        msk[i] <= ld_mask;
      end else if (clr_en && clr_slot == SW'(i)) begin
        vld[i] <= 1'b0;
        msk[i] <= '0;
      end
    end
    assign hit_vec[i] = vld[i] && (blk[i] == lk_block) && msk[i][lk_page];
  end

  always_comb begin
    lk_hit  = |hit_vec;
    lk_slot = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--)
      if (hit_vec[i]) lk_slot = SW'(i);
  end

  // R2: a block address lives in at most one slot, so at most one hit
  p_single_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit_vec) <= 1);
  // R11: a load leaves the slot occupied
  p_load_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> vld[$past(ld_slot)]);
  // R10: a release leaves the slot empty
  p_clear_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !ld_en) |=> !vld[$past(clr_slot)]);
endmodule

// File: rtl/bsc_flush_seq.sv
module bsc_flush_seq
  import bsc_pkg::*;
#(
  parameter int PAGES = 64,
  parameter int BLK_W = 16,
  parameter int SW    = 1,
  parameter int PGW   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SW-1:0]    start_slot,
  input  logic [BLK_W-1:0] start_block,
  input  logic [PAGES-1:0] start_mask,
  input  logic [PAGES-1:0] live,
  input  logic             fc_done,
  output logic             fc_valid,
  output fop_e             fc_op,
  output logic [BLK_W-1:0] fc_block,
  output logic [PGW-1:0]   fc_page,
  output logic             busy,
  output logic             fin,
  output logic [SW-1:0]    slot_q
);
  localparam logic [PGW-1:0] LAST_PG = PGW'(PAGES - 1);

  // Lowest set bit of a page mask; the merge walks pages upward.
  function automatic logic [PGW-1:0] lowest_page(input logic [PAGES-1:0] m);
    lowest_page = '0;
    for (int i = PAGES - 1; i >= 0; i--)
      if (m[i]) lowest_page = PGW'(i);
  endfunction

  // Pages to fetch: absent from the slot yet still live in flash.
  function automatic logic [PAGES-1:0] merge_set(input logic [PAGES-1:0] slot_m,
                                                 input logic [PAGES-1:0] live_m);
    merge_set = live_m & ~slot_m;
  endfunction

  seq_st_e          st_q;
  logic [PAGES-1:0] pend_q, need_q;
  logic             full_q;
  logic [PGW-1:0]   wpage_q;
  logic [PGW-1:0]   rd_page;
  logic [PAGES-1:0] rd_bit;
  logic [PAGES-1:0] start_need;

  assign rd_page    = lowest_page(pend_q);
  assign rd_bit     = {{(PAGES-1){1'b0}}, 1'b1} << rd_page;
  assign start_need = merge_set(start_mask, live);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= SQ_IDLE;
      pend_q   <= '0;
      need_q   <= '0;
      full_q   <= 1'b0;
      wpage_q  <= '0;
      fc_block <= '0;
      slot_q   <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: if (start) begin
          fc_block <= start_block;
          slot_q   <= start_slot;
          pend_q   <= start_need;
          need_q   <= start_need;
          full_q   <= &start_mask;
          wpage_q  <= '0;
          st_q     <= (|start_need) ? SQ_READ : SQ_ERASE;
        end
        SQ_READ: if (fc_done) begin
          pend_q <= pend_q & ~rd_bit;
          if ((pend_q & ~rd_bit) == '0) st_q <= SQ_ERASE;
        end
        SQ_ERASE: if (fc_done) begin
          wpage_q <= '0;
          st_q    <= SQ_WRITE;
        end
        SQ_WRITE: if (fc_done) begin
          if (wpage_q == LAST_PG) st_q <= SQ_IDLE;
          else                    wpage_q <= wpage_q + 1'b1;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    fc_valid = (st_q != SQ_IDLE);
    busy     = fc_valid;
    fin      = (st_q == SQ_WRITE) && fc_done && (wpage_q == LAST_PG);
    case (st_q)
      SQ_READ:  begin fc_op = FOP_READ;  fc_page = rd_page; end
      SQ_ERASE: begin fc_op = FOP_ERASE; fc_page = '0;      end
      SQ_WRITE: begin fc_op = FOP_WRITE; fc_page = wpage_q; end
      default:  begin fc_op = FOP_NONE;  fc_page = '0;      end
    endcase
  end

  // R5: every read targets a page that needed merging
  p_read_needed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_valid && fc_op == FOP_READ) |-> need_q[fc_page]);
  // R5: merge reads move strictly upward
  p_read_ascend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_op == FOP_READ && fc_done && st_q == SQ_READ && (pend_q & ~rd_bit) != '0)
      |=> (fc_op == FOP_READ && fc_page > $past(fc_page)));
  // R6: the erase only follows once no merge read remains
  p_erase_after_merge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_valid && fc_op == FOP_ERASE) |-> (pend_q == '0));
  // R7: writes advance one page per completion
  p_write_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_WRITE && fc_done && wpage_q != LAST_PG)
      |=> (fc_op == FOP_WRITE && fc_page == $past(fc_page) + 1'b1));
  // R8: a full slot never causes a read
  p_full_noread_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_valid && fc_op == FOP_READ) |-> !full_q);
  // R9: command held steady until its done pulse
  p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_valid && !fc_done) |=> (fc_valid && $stable(fc_op) && $stable(fc_page)
                                && $stable(fc_block)));
endmodule

// File: rtl/bsc_block_space.sv
module bsc_block_space
  import bsc_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int PAGES     = 64,
  parameter int BLK_W     = 16,
  localparam int SW       = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int PGW      = $clog2(PAGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic             swap_en,
  input  logic [SW-1:0]    cmd_slot,
  input  logic [BLK_W-1:0] cmd_block,
  input  logic [PAGES-1:0] cmd_mask,
  output logic             hand_valid,
  output logic [BLK_W-1:0] hand_block,
  output logic [PAGES-1:0] hand_mask,
  input  logic             lk_en,
  input  logic [BLK_W-1:0] lk_block,
  input  logic [PGW-1:0]   lk_page,
  output logic             lk_hit,
  output logic [SW-1:0]    lk_slot,
  output logic [SW-1:0]    lru_slot,
  output logic [BLK_W-1:0] lru_block,
  input  logic             flush_req,
  input  logic [PAGES-1:0] flash_live,
  output logic             fc_valid,
  output logic [1:0]       fc_op,
  output logic [BLK_W-1:0] fc_block,
  output logic [PGW-1:0]   fc_page,
  input  logic             fc_done,
  output logic             busy,
  output logic             free_valid,
  output logic [SW-1:0]    free_slot
);
  logic [NUM_SLOTS-1:0]             slot_vld;
  logic [NUM_SLOTS-1:0][BLK_W-1:0]  slot_blk;
  logic [NUM_SLOTS-1:0][PAGES-1:0]  slot_msk;

  logic          seq_busy, seq_fin;
  logic [SW-1:0] seq_slot;
  fop_e          seq_op;
  logic          slot_ok, all_full, idle;
  logic          flush_go, swap_go, fill_go, ld_go;
  logic          touch_en;
  logic [SW-1:0] touch_slot;

  assign idle     = !seq_busy;
  assign all_full = &slot_vld;
  assign slot_ok  = ({1'b0, cmd_slot} < (SW + 1)'(NUM_SLOTS));
  assign flush_go = flush_req && idle && all_full;
  assign swap_go  = swap_en && idle && !flush_req && slot_ok && slot_vld[cmd_slot];
  assign fill_go  = fill_en && idle && !flush_req && !swap_en && slot_ok
                    && !slot_vld[cmd_slot];
  assign ld_go    = swap_go || fill_go;

  always_comb begin
    touch_en   = ld_go || (lk_en && lk_hit);
    touch_slot = ld_go ? cmd_slot : lk_slot;
  end

  bsc_slot_store #(
    .NUM_SLOTS(NUM_SLOTS), .PAGES(PAGES), .BLK_W(BLK_W), .SW(SW), .PGW(PGW)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_go), .ld_slot(cmd_slot), .ld_block(cmd_block), .ld_mask(cmd_mask),
    .clr_en(seq_fin), .clr_slot(seq_slot),
    .lk_block(lk_block), .lk_page(lk_page), .lk_hit(lk_hit), .lk_slot(lk_slot),
    .vld(slot_vld), .blk(slot_blk), .msk(slot_msk)
  );

  bsc_lru #(.NUM_SLOTS(NUM_SLOTS), .SW(SW)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .touch_en(touch_en), .touch_slot(touch_slot), .lru_slot(lru_slot)
  );

  assign lru_block = slot_blk[lru_slot];

  bsc_flush_seq #(.PAGES(PAGES), .BLK_W(BLK_W), .SW(SW), .PGW(PGW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(flush_go), .start_slot(lru_slot), .start_block(slot_blk[lru_slot]),
    .start_mask(slot_msk[lru_slot]), .live(flash_live),
    .fc_done(fc_done), .fc_valid(fc_valid), .fc_op(seq_op), .fc_block(fc_block),
    .fc_page(fc_page), .busy(seq_busy), .fin(seq_fin), .slot_q(seq_slot)
  );

  assign fc_op = seq_op;
  assign busy  = seq_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hand_valid <= 1'b0;
      hand_block <= '0;
      hand_mask  <= '0;
    end else begin
      hand_valid <= swap_go;
      if (swap_go) begin
        hand_block <= slot_blk[cmd_slot];
        hand_mask  <= slot_msk[cmd_slot];
      end
    end
  end

  always_comb begin
    free_valid = idle && !all_full;
    free_slot  = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--)
      if (!slot_vld[i]) free_slot = SW'(i);
  end

  // R4: an accepted flush raises busy on the next cycle
  p_flush_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_go |=> busy);
  // R4: a flush is never started while a slot is empty
  p_flush_needs_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy)) |-> $past(all_full));
  // R10: last write completion frees the slot and ends busy
  p_fin_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fin |=> (!busy && free_valid));
  // R11: a handback never coincides with flash activity
  p_swap_noflash_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hand_valid |-> !fc_valid);
  // R12: occupancy frozen while an eviction runs
  p_busy_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_fin) |=> $stable(slot_vld));
endmodule

// File: tb/bsc_block_space_test.sv
module bsc_block_space_test;
  localparam int P = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fill_en = 0, swap_en = 0, lk_en = 0, flush_req = 0, fc_done = 0;
  logic [0:0]  cmd_slot = '0;
  logic [15:0] cmd_block = '0, lk_block = '0;
  logic [63:0] cmd_mask = '0, flash_live = '0;
  logic [5:0]  lk_page = '0;
  logic        hand_valid, lk_hit, fc_valid, busy, free_valid;
  logic [15:0] hand_block, lru_block, fc_block;
  logic [63:0] hand_mask;
  logic [0:0]  lk_slot, lru_slot, free_slot;
  logic [1:0]  fc_op;
  logic [5:0]  fc_page;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int exp_op [200];
  int exp_pg [200];
  int bench_lru;

  always #4 clk = ~clk;

  bsc_block_space uut (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .swap_en(swap_en),
    .cmd_slot(cmd_slot), .cmd_block(cmd_block), .cmd_mask(cmd_mask),
    .hand_valid(hand_valid), .hand_block(hand_block), .hand_mask(hand_mask),
    .lk_en(lk_en), .lk_block(lk_block), .lk_page(lk_page), .lk_hit(lk_hit),
    .lk_slot(lk_slot), .lru_slot(lru_slot), .lru_block(lru_block),
    .flush_req(flush_req), .flash_live(flash_live), .fc_valid(fc_valid),
    .fc_op(fc_op), .fc_block(fc_block), .fc_page(fc_page), .fc_done(fc_done),
    .busy(busy), .free_valid(free_valid), .free_slot(free_slot)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic do_fill(input int s, input logic [15:0] b, input logic [63:0] m);
    @(negedge clk);
    fill_en = 1; cmd_slot = 1'(s); cmd_block = b; cmd_mask = m;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic do_swap(input int s, input logic [15:0] b, input logic [63:0] m);
    @(negedge clk);
    swap_en = 1; cmd_slot = 1'(s); cmd_block = b; cmd_mask = m;
    @(negedge clk);
    swap_en = 0;
  endtask

  task automatic look(input logic [15:0] b, input int pg, output bit hit, output int s);
    @(negedge clk);
    lk_en = 1; lk_block = b; lk_page = 6'(pg);
    #1;
    hit = lk_hit; s = int'(lk_slot);
    if (hit) bench_lru = 1 - s;
    @(negedge clk);
    lk_en = 0;
  endtask

  // Expected command stream from the requirements: reads, erase, writes.
  task automatic serve(input logic [63:0] m, input logic [63:0] live,
                       input logic [15:0] b);
    int n = 0;
    for (int p = 0; p < P; p++)
      if (live[p] && !m[p]) begin exp_op[n] = 1; exp_pg[n] = p; n++; end
    exp_op[n] = 3; exp_pg[n] = 0; n++;
    for (int p = 0; p < P; p++) begin exp_op[n] = 2; exp_pg[n] = p; n++; end
    for (int k = 0; k < n; k++) begin
      string tag;
      tag = (exp_op[k] == 1) ? "R5" : (exp_op[k] == 3) ? "R6" : "R7";
      chk(fc_valid && int'(fc_op) == exp_op[k] && int'(fc_page) == exp_pg[k]
          && fc_block == b, tag, {fc_block, 38'd0, fc_op, fc_page},
          {b, 38'd0, 2'(exp_op[k]), 6'(exp_pg[k])});
      for (int w = 0; w < k % 3; w++) begin
        @(negedge clk);
        if (w == 1)
          chk(fc_valid && int'(fc_page) == exp_pg[k] && int'(fc_op) == exp_op[k],
              "R9 hold", {56'd0, fc_op, fc_page}, 64'(exp_pg[k]));
      end
      fc_done = 1;
      @(negedge clk);
      fc_done = 0;
      if (k < n - 1) chk(fc_valid, "R9 next", 64'(fc_valid), 64'd1);
      else           chk(!busy && !fc_valid, "R10 idle", 64'(busy), 64'd0);
    end
  endtask

  // Lookup table: {block, page, expected hit, expected slot}
  localparam logic [31:0] LOOK_TAB [6] = '{
    {16'd5, 8'd0,  4'd1, 4'd0},
    {16'd5, 8'd31, 4'd1, 4'd0},
    {16'd5, 8'd32, 4'd0, 4'd0},
    {16'd9, 8'd63, 4'd1, 4'd1},
    {16'd7, 8'd3,  4'd0, 4'd0},
    {16'd9, 8'd0,  4'd1, 4'd1}
  };

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit h; int s;
    logic [63:0] lo_half, live1;
    lo_half = 64'h0000_0000_FFFF_FFFF;
    live1   = (64'd1 << 32) | (64'd1 << 40) | (64'd1 << 63) | (64'd1 << 3);
    bench_lru = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(free_valid && free_slot == 0, "R1 free", {free_valid, 63'(free_slot)}, {1'b1, 63'd0});
    chk(!busy && !fc_valid, "R1 idle", {busy, 63'(fc_valid)}, 64'd0);
    chk(lru_slot == 1, "R1 lru", 64'(lru_slot), 64'd1);

    do_fill(0, 16'd5, lo_half);
    chk(lru_slot == 1, "R3 after fill0", 64'(lru_slot), 64'd1);
    do_fill(1, 16'd9, '1);
    bench_lru = 0;
    chk(lru_slot == 0 && lru_block == 5, "R3 after fill1", {lru_block, 48'(lru_slot)},
        {16'd5, 48'd0});
    chk(!free_valid, "R1 full", 64'(free_valid), 64'd0);

    // R2 table walk
    foreach (LOOK_TAB[i]) begin
      look(LOOK_TAB[i][31:16], int'(LOOK_TAB[i][15:8]), h, s);
      chk(h == LOOK_TAB[i][4] && (!h || s == int'(LOOK_TAB[i][3:0])), "R2 lookup",
          {32'(h), 32'(s)}, {32'(LOOK_TAB[i][7:4]), 32'(LOOK_TAB[i][3:0])});
    end
    chk(int'(lru_slot) == bench_lru, "R3 table lru", 64'(lru_slot), 64'(bench_lru));
    look(16'd5, 1, h, s);
    chk(int'(lru_slot) == bench_lru && bench_lru == 1, "R3 hit touch", 64'(lru_slot), 64'(bench_lru));

    // R12 load to an occupied slot is ignored
    do_fill(0, 16'd77, '1);
    look(16'd77, 0, h, s);
    chk(!h, "R12 fill occupied", 64'(h), 64'd0);
    look(16'd5, 0, h, s);
    chk(h && s == 0, "R12 content kept", 64'(h), 64'd1);

    // R11 exchange
    do_swap(1, 16'd12, 64'hF0);
    chk(hand_valid && hand_block == 9 && hand_mask == '1, "R11 handback",
        {hand_block, 47'd0, hand_valid}, {16'd9, 47'd0, 1'b1});
    chk(!fc_valid, "R11 no flash", 64'(fc_valid), 64'd0);
    bench_lru = 0;
    look(16'd12, 4, h, s);
    chk(h && s == 1, "R11 new content", 64'(h), 64'd1);
    look(16'd9, 0, h, s);
    chk(!h, "R11 old gone", 64'(h), 64'd0);
    chk(lru_slot == 0, "R3 after swap", 64'(lru_slot), 64'd0);

    // R4..R7 flush with late merge
    @(negedge clk);
    flush_req = 1; flash_live = live1;
    @(negedge clk);
    flush_req = 0; flash_live = '0;
    chk(busy, "R4 busy", 64'(busy), 64'd1);
    do_swap(1, 16'd99, '1);
    chk(!hand_valid, "R12 swap while busy", 64'(hand_valid), 64'd0);
    serve(lo_half, live1, 16'd5);
    chk(free_valid && free_slot == 0, "R10 free", {free_valid, 63'(free_slot)}, {1'b1, 63'd0});
    look(16'd5, 0, h, s);
    chk(!h, "R10 evicted misses", 64'(h), 64'd0);
    look(16'd99, 0, h, s);
    chk(!h, "R12 swap ignored", 64'(h), 64'd0);
    look(16'd12, 4, h, s);
    chk(h && s == 1, "R12 slot1 kept", 64'(h), 64'd1);

    // R4 flush ignored while a slot is empty
    @(negedge clk);
    flush_req = 1;
    @(negedge clk);
    flush_req = 0;
    chk(!busy && !fc_valid, "R4 ignored", {busy, 63'(fc_valid)}, 64'd0);

    // R8 full slot: no merge reads
    do_fill(0, 16'd20, '1);
    look(16'd12, 4, h, s);
    chk(lru_slot == 0 && lru_block == 20, "R3 lru full", {lru_block, 48'(lru_slot)},
        {16'd20, 48'd0});
    @(negedge clk);
    flush_req = 1; flash_live = '1;
    @(negedge clk);
    flush_req = 0;
    chk(fc_valid && fc_op == 2'd3, "R8 erase first", 64'(fc_op), 64'd3);
    serve('1, '1, 16'd20);
    chk(free_valid && free_slot == 0, "R10 free again", 64'(free_slot), 64'd0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule